// File: doc/BRIEF.md
# Station-Management Register Responder

This block is the target side of a two-wire management link. It watches the management data line on each rising edge of the management clock and decodes clause-22 frames. A frame is an optional run of ones, a start pair `01`, a two-bit opcode, a 5-bit station address, a 5-bit register address, two turnaround bits and 16 data bits. All fields are sent MSB first. A frame whose station address matches the configured one reaches a bank of 32 registers of 16 bits each. The block answers reads by driving the data line. It applies writes after the last data bit.

In normal mode, register 0 holds control settings. Its bits 15 and 9 clear themselves. Registers 1 to 3 are fixed status and identifier words that ignore writes, and every other address reads as a fixed fill word. In test mode, all 32 addresses become plain read/write storage, and frames for any station address are accepted. A clear input zeroes that storage. A preamble-skip option accepts a start pair that has no run of ones before it.

Top module: `mdio_phy_resp`

## Requirements
- R1: While `rst_n` is low at a rising `mdc` edge, the next cycle has `mdio_oe` low. After reset, register 0 reads 0x3100.
- R2: In normal mode, a read of any register address from 4 to 31 returns 0xDEAD. A write to those addresses changes nothing.
- R3: In normal mode, registers 1, 2 and 3 read 0x7849, 0x0141 and 0x0C2A. A write to any of them leaves its value unchanged.
- R4: A write to register 0 with bit 15 clear stores the data with bits 15 and 9 forced to 0. Writing 0x7DFF reads back 0x7DFF, and writing 0x1234 reads back 0x1034.
- R5: A write to register 0 with bit 15 set returns register 0 to 0x3100, whatever the other data bits are.
- R6: In normal mode, a frame whose station address differs from `phy_addr_cfg` gets no response (`mdio_oe` stays low) and does not change any register.
- R7: With `test_mode` high, each of the 32 addresses stores the last 16-bit word written to it. Frames are accepted for every station address.
- R8: With `no_preamble` low, a start pair is accepted only if at least 32 consecutive ones came just before it. 31 ones are not enough.
- R9: With `no_preamble` high, a frame whose start pair has no ones before it is served normally.
- R10: The read opcode is `10`. For a read that is served, `mdio_oe` stays low through the first turnaround bit. The block then drives 0 for the second turnaround bit and the 16 data bits MSB first, which is 17 bit times, and releases the line after that.
- R11: A one-cycle pulse on `clr_test` sets all 32 test-mode words to 0.
- R12: The write opcode is `01`. During a write frame `mdio_oe` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mdio_i | input | 1 | Management data line as seen by the responder |
| phy_addr_cfg | input | 5 | Station address this responder answers in normal mode |
| test_mode | input | 1 | All registers writable, any station address accepted |
| no_preamble | input | 1 | Accept a start pair without a preceding run of ones |
| clr_test | input | 1 | Zero all test-mode storage |
| mdio_o | output | 1 | Data driven onto the line during a read response |
| mdio_oe | output | 1 | High while the responder drives the line |

## Verification
If the frame decoder falls out of step, the effect shows within one frame. The response can start a bit early or late, run longer or shorter than 17 bit times, or be missing entirely. The bench records `mdio_oe` and `mdio_o` at every bit of each read, so a single bit of skew shows up as a miscompare on that read. A wrong register value shows up at the next read of that address. For that reason, every write in the bench is followed by a read of the same address, and every address is read in both modes.

// File: rtl/mdio_resp_pkg.sv
// Shared types for the station-management responder.
// Assumes a clause-22 frame layout: start 01, 2-bit opcode, two 5-bit addresses.
package mdio_resp_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,   // counting ones, waiting for a start pair
        RX_START = 2'd1,   // first start bit (0) seen
        RX_HEAD  = 2'd2,   // shifting opcode and addresses
        RX_BODY  = 2'd3    // turnaround and data bits
    } rx_state_t;

    typedef enum logic [1:0] {
        ACT_SKIP  = 2'd0,
        ACT_READ  = 2'd1,
        ACT_WRITE = 2'd2
    } frame_act_t;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

endpackage

// File: rtl/mdio_rx_fsm.sv
// Frame decoder and read serializer for the management link.
// Samples mdio_i on each rising clock edge. It finds the start pair, then
// shifts in the header. A frame is served if the station address matches
// (or match_all is set). The serializer drives read data back, and the
// decoder emits a one-cycle write strobe after the last data bit.
// Assumes rd_data is a combinational function of reg_addr.
module mdio_rx_fsm
    import mdio_resp_pkg::*;
#(
    parameter int AW      = 5,
    parameter int DW      = 16,
    parameter int PRE_LEN = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mdio_i,
    input  logic          no_preamble,
    input  logic          match_all,
    input  logic [AW-1:0] phy_addr_cfg,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] reg_addr,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data,
    output logic          mdio_o,
    output logic          mdio_oe
);

    localparam int HDR_LEN  = 2 + 2 * AW;
    localparam int BODY_LEN = 2 + DW;
    localparam int CNT_MAX  = (HDR_LEN > BODY_LEN) ? HDR_LEN : BODY_LEN;
    localparam int CNT_W    = $clog2(CNT_MAX);
    localparam int PRE_W    = $clog2(PRE_LEN + 1);

    rx_state_t          state_q;
    frame_act_t         act_q;
    logic [PRE_W-1:0]   ones_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [HDR_LEN-1:0] hdr_q;
    logic [HDR_LEN-1:0] hdr_next;
    logic [DW-1:0]      tx_q;
    logic [DW-1:0]      rx_q;
    logic [1:0]         hdr_op;
    logic [AW-1:0]      hdr_phy;
    logic               hdr_hit;

    // Split the completed header into its fields.
    always_comb begin
        hdr_next = {hdr_q[HDR_LEN-2:0], mdio_i};
        hdr_op   = hdr_next[HDR_LEN-1 -: 2];
        hdr_phy  = hdr_next[2*AW-1 -: AW];
        hdr_hit  = match_all || (hdr_phy == phy_addr_cfg);
    end

    // Frame state machine, read serializer and write capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RX_IDLE;
            act_q    <= ACT_SKIP;
            ones_q   <= '0;
            cnt_q    <= '0;
            hdr_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            reg_addr <= '0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
            mdio_o   <= 1'b0;
            mdio_oe  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (mdio_i) begin
                        if (ones_q != PRE_W'(PRE_LEN)) ones_q <= ones_q + 1'b1;
                    end else begin
                        if (no_preamble || ones_q == PRE_W'(PRE_LEN)) state_q <= RX_START;
                        ones_q <= '0;
                    end
                end
                RX_START: begin
                    state_q <= mdio_i ? RX_HEAD : RX_IDLE;
                    cnt_q   <= '0;
                end
                RX_HEAD: begin
                    hdr_q <= hdr_next;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(HDR_LEN - 1)) begin
                        state_q  <= RX_BODY;
                        cnt_q    <= '0;
                        reg_addr <= hdr_next[AW-1:0];
                        if (hdr_hit && hdr_op == OPC_READ)       act_q <= ACT_READ;
                        else if (hdr_hit && hdr_op == OPC_WRITE) act_q <= ACT_WRITE;
                        else                                     act_q <= ACT_SKIP;
                    end
                end
                RX_BODY: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (act_q == ACT_READ) begin
                        if (cnt_q == '0) begin
                            mdio_oe <= 1'b1;
                            mdio_o  <= 1'b0;
                            tx_q    <= rd_data;
                        end else if (cnt_q <= CNT_W'(DW)) begin
                            mdio_o <= tx_q[DW-1];
                            tx_q   <= {tx_q[DW-2:0], 1'b0};
                        end
                    end
                    if (act_q == ACT_WRITE && cnt_q >= CNT_W'(2)) begin
                        rx_q <= {rx_q[DW-2:0], mdio_i};
                    end
                    if (cnt_q == CNT_W'(BODY_LEN - 1)) begin
                        state_q <= RX_IDLE;
                        ones_q  <= '0;
                        mdio_oe <= 1'b0;
                        mdio_o  <= 1'b0;
                        wr_stb  <= (act_q == ACT_WRITE);
                        wr_data <= {rx_q[DW-2:0], mdio_i};
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mdio_reg_bank.sv
// Register bank behind the management link.
// Normal mode has a control word with self-clearing bits and a reset bit,
// fixed status and identifier words, and a fill word for the rest.
// Test mode has a separate array of fully writable words.
// Assumes wr_stb is a single-cycle pulse and that CTRL_INIT has no
// self-clearing bit set.
module mdio_reg_bank #(
    parameter int          AW         = 5,
    parameter int          DW         = 16,
    parameter int          RST_BIT    = 15,
    parameter logic [15:0] SC_MASK    = 16'h8200,
    parameter logic [15:0] CTRL_INIT  = 16'h3100,
    parameter logic [15:0] STATUS_VAL = 16'h7849,
    parameter logic [15:0] ID_HI      = 16'h0141,
    parameter logic [15:0] ID_LO      = 16'h0C2A,
    parameter logic [15:0] FILL_VAL   = 16'hDEAD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_mode,
    input  logic          clr_test,
    input  logic          wr_stb,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] ctrl_q
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0] test_q [NREG];

    // Control word: a write with the reset bit reloads the default; otherwise
    // the self-clearing bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= DW'(CTRL_INIT);
        end else if (wr_stb && !test_mode && addr == '0) begin
            ctrl_q <= wr_data[RST_BIT] ? DW'(CTRL_INIT) : (wr_data & ~DW'(SC_MASK));
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_test
        // One test-mode word; reset or clear zeroes it.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_test) begin
                test_q[g] <= '0;
            end else if (wr_stb && test_mode && addr == AW'(g)) begin
                test_q[g] <= wr_data;
            end
        end
    end

    // Read selection by mode and address.
    always_comb begin
        if (test_mode) begin
            rd_data = test_q[addr];
        end else begin
            case (addr)
                AW'(0):  rd_data = ctrl_q;
                AW'(1):  rd_data = DW'(STATUS_VAL);
                AW'(2):  rd_data = DW'(ID_HI);
                AW'(3):  rd_data = DW'(ID_LO);
                default: rd_data = DW'(FILL_VAL);
            endcase
        end
    end

endmodule

// File: rtl/mdio_phy_resp.sv
// Station-management responder top: frame decoder plus register bank.
// Clocked by the management clock itself with a synchronous active-low
// reset. The caller combines mdio_o and mdio_oe into the shared line.
module mdio_phy_resp #(
    parameter int          AW         = 5,
    parameter int          DW         = 16,
    parameter int          PRE_LEN    = 32,
    parameter logic [15:0] CTRL_INIT  = 16'h3100,
    parameter logic [15:0] STATUS_VAL = 16'h7849,
    parameter logic [15:0] ID_HI      = 16'h0141,
    parameter logic [15:0] ID_LO      = 16'h0C2A,
    parameter logic [15:0] FILL_VAL   = 16'hDEAD
) (
    input  logic          mdc,
    input  logic          rst_n,
    input  logic          mdio_i,
    input  logic [AW-1:0] phy_addr_cfg,
    input  logic          test_mode,
    input  logic          no_preamble,
    input  logic          clr_test,
    output logic          mdio_o,
    output logic          mdio_oe
);

    logic [AW-1:0] reg_addr;
    logic          wr_stb;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] ctrl_q;

    mdio_rx_fsm #(.AW(AW), .DW(DW), .PRE_LEN(PRE_LEN)) u_rx (
        .clk          (mdc),
        .rst_n        (rst_n),
        .mdio_i       (mdio_i),
        .no_preamble  (no_preamble),
        .match_all    (test_mode),
        .phy_addr_cfg (phy_addr_cfg),
        .rd_data      (rd_data),
        .reg_addr     (reg_addr),
        .wr_stb       (wr_stb),
        .wr_data      (wr_data),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe)
    );

    mdio_reg_bank #(
        .AW(AW), .DW(DW), .CTRL_INIT(CTRL_INIT), .STATUS_VAL(STATUS_VAL),
        .ID_HI(ID_HI), .ID_LO(ID_LO), .FILL_VAL(FILL_VAL)
    ) u_bank (
        .clk       (mdc),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .clr_test  (clr_test),
        .wr_stb    (wr_stb),
        .addr      (reg_addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .ctrl_q    (ctrl_q)
    );

endmodule

// File: rtl/mdio_phy_resp_chk.sv
// Protocol checker for the responder, attached by bind.
// Tracks how long the line is driven with its own counter.
module mdio_phy_resp_chk #(
    parameter int          DW       = 16,
    parameter logic [15:0] SC_MASK  = 16'h8200,
    parameter int          RESP_LEN = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mdio_o,
    input logic          mdio_oe,
    input logic          wr_stb,
    input logic [DW-1:0] ctrl_q
);

    logic [7:0] oe_run;

    // Count consecutive cycles with the line driven.
    always_ff @(posedge clk) begin
        if (!rst_n)       oe_run <= '0;
        else if (mdio_oe) oe_run <= oe_run + 1'b1;
        else              oe_run <= '0;
    end

    AST_RESET_RELEASES: assert property (@(posedge clk) !rst_n |=> !mdio_oe); // R1
    AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(mdio_oe) |-> !mdio_o); // R10
    AST_DRIVE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) mdio_oe |-> oe_run < 8'(RESP_LEN)); // R10
    AST_DRIVE_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(mdio_oe) |-> oe_run == 8'(RESP_LEN)); // R10
    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q & DW'(SC_MASK)) == '0); // R4
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> !mdio_oe); // R12

endmodule

bind mdio_phy_resp mdio_phy_resp_chk #(.DW(16)) u_chk (
    .clk     (mdc),
    .rst_n   (rst_n),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .wr_stb  (wr_stb),
    .ctrl_q  (ctrl_q)
);

// File: tb/mdio_phy_resp_test.sv
// Bench: drives frames bit by bit on falling edges, samples on falling edges.
module mdio_phy_resp_test;

    logic       mdc = 1'b0;
    logic       rst_n = 1'b0;
    logic       mdio_i = 1'b1;
    logic [4:0] phy_addr_cfg = 5'd1;
    logic       test_mode = 1'b0;
    logic       no_preamble = 1'b0;
    logic       clr_test = 1'b0;
    logic       mdio_o;
    logic       mdio_oe;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #10 mdc = ~mdc;

    mdio_phy_resp uut (
        .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .phy_addr_cfg(phy_addr_cfg),
        .test_mode(test_mode), .no_preamble(no_preamble), .clr_test(clr_test),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge mdc);
        mdio_i = b;
    endtask

    task automatic send_break();
        send_bit(1'b0);
        send_bit(1'b0);
    endtask

    task automatic send_head(input int npre, input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
        for (int i = 0; i < npre; i++) send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b1);
        send_bit(op[1]); send_bit(op[0]);
        for (int i = 4; i >= 0; i--) send_bit(pa[i]);
        for (int i = 4; i >= 0; i--) send_bit(ra[i]);
    endtask

    // Write frame; checks the line is never driven (R12).
    task automatic do_write(input int npre, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
        logic seen;
        seen = 1'b0;
        send_head(npre, 2'b01, pa, ra);
        send_bit(1'b1); seen |= mdio_oe;
        send_bit(1'b0); seen |= mdio_oe;
        for (int i = 15; i >= 0; i--) begin
            send_bit(d[i]);
            seen |= mdio_oe;
        end
        send_bit(1'b1); seen |= mdio_oe;
        send_bit(1'b1); seen |= mdio_oe;
        chk("R12 no drive in write", 16'(seen), 16'h0);
    endtask

    // Read frame; records the 19 bit times after the header.
    task automatic do_read(input int npre, input logic [4:0] pa, input logic [4:0] ra,
                           output logic [15:0] d, output bit resp, output bit shape_ok);
        logic oe_s [19];
        logic o_s  [19];
        bit   any;
        send_head(npre, 2'b10, pa, ra);
        for (int k = 0; k < 19; k++) begin
            @(negedge mdc);
            oe_s[k] = mdio_oe;
            o_s[k]  = mdio_o;
            mdio_i  = 1'b1;
        end
        any = 0;
        for (int k = 0; k < 19; k++) any |= oe_s[k];
        resp = oe_s[1];
        shape_ok = !oe_s[0] && oe_s[1] && !o_s[1] && !oe_s[18];
        for (int k = 2; k < 18; k++) begin
            shape_ok &= oe_s[k];
            d[17-k] = o_s[k];
        end
        if (!any) begin
            d = 16'h0;
            shape_ok = 1;
        end
    endtask

    function automatic logic [15:0] exp_normal(input int a, input logic [15:0] ctrl);
        case (a)
            0:       return ctrl;
            1:       return 16'h7849;
            2:       return 16'h0141;
            3:       return 16'h0C2A;
            default: return 16'hDEAD;
        endcase
    endfunction

    function automatic logic [15:0] pat(input int a);
        return 16'h5A5A ^ 16'(a * 16'h0801);
    endfunction

    // Read and check both data and response shape.
    task automatic rd_chk(input string req, input int npre, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] exp);
        logic [15:0] d;
        bit r, s;
        do_read(npre, pa, ra, d, r, s);
        chk({req, " responded"}, 16'(r), 16'h1);
        chk("R10 response shape", 16'(s), 16'h1);
        chk(req, d, exp);
    endtask

    task automatic rd_none(input string req, input int npre, input logic [4:0] pa, input logic [4:0] ra);
        logic [15:0] d;
        bit r, s;
        do_read(npre, pa, ra, d, r, s);
        chk({req, " silent"}, 16'(r), 16'h0);
        chk({req, " line idle"}, d, 16'h0);
    endtask

    initial begin
        repeat (4) @(negedge mdc);
        chk("R1 oe low in reset", 16'(mdio_oe), 16'h0);
        rst_n = 1'b1;
        @(negedge mdc);
        chk("R1 oe low after reset", 16'(mdio_oe), 16'h0);
        rd_chk("R1 control default", 32, 5'd1, 5'd0, 16'h3100);

        // R2 R3: full sweep of normal-mode read map
        for (int a = 0; a < 32; a++)
            rd_chk(a < 4 ? "R3 fixed word" : "R2 fill word", 32, 5'd1, 5'(a), exp_normal(a, 16'h3100));

        // R4: self-clearing bits
        do_write(32, 5'd1, 5'd0, 16'h7DFF);
        rd_chk("R4 write 7DFF", 32, 5'd1, 5'd0, 16'h7DFF);
        do_write(32, 5'd1, 5'd0, 16'h1234);
        rd_chk("R4 bit 9 cleared", 32, 5'd1, 5'd0, 16'h1034);

        // R5: reset bit reloads default
        do_write(32, 5'd1, 5'd0, 16'hFFFF);
        rd_chk("R5 reset bit", 32, 5'd1, 5'd0, 16'h3100);
        do_write(32, 5'd1, 5'd0, 16'h0055);
        do_write(32, 5'd1, 5'd0, 16'h8055);
        rd_chk("R5 reset bit with data", 32, 5'd1, 5'd0, 16'h3100);

        // R3 R2: writes to read-only addresses ignored
        for (int a = 1; a < 4; a++) begin
            do_write(32, 5'd1, 5'(a), ~exp_normal(a, 16'h0));
            rd_chk("R3 write ignored", 32, 5'd1, 5'(a), exp_normal(a, 16'h0));
        end
        do_write(32, 5'd1, 5'd4, 16'h1111);
        rd_chk("R2 write ignored", 32, 5'd1, 5'd4, 16'hDEAD);
        do_write(32, 5'd1, 5'd31, 16'h2222);
        rd_chk("R2 write ignored top", 32, 5'd1, 5'd31, 16'hDEAD);

        // R6: foreign station addresses
        for (int p = 0; p < 32; p++) begin
            if (p == 1) rd_chk("R6 own address", 32, 5'(p), 5'd2, 16'h0141);
            else        rd_none("R6 foreign address", 32, 5'(p), 5'd2);
        end
        do_write(32, 5'd2, 5'd0, 16'h0000);
        rd_chk("R6 foreign write ignored", 32, 5'd1, 5'd0, 16'h3100);

        // R8: preamble length boundary
        send_break();
        rd_none("R8 31 ones", 31, 5'd1, 5'd3);
        send_break();
        rd_none("R8 no ones", 0, 5'd1, 5'd3);
        send_break();
        rd_chk("R8 exactly 32 ones", 32, 5'd1, 5'd3, 16'h0C2A);

        // R9: preamble skipped
        no_preamble = 1'b1;
        send_break();
        rd_chk("R9 no preamble read", 0, 5'd1, 5'd1, 16'h7849);
        do_write(0, 5'd1, 5'd0, 16'h0140);
        rd_chk("R9 no preamble write", 0, 5'd1, 5'd0, 16'h0140);
        send_break();
        no_preamble = 1'b0;

        // R7: test mode, walking one across station and register address
        test_mode = 1'b1;
        for (int i = 0; i < 5; i++) begin
            do_write(32, 5'(1 << i), 5'(1 << i), pat(i + 40));
            rd_chk("R7 walking address", 32, 5'(1 << i), 5'(1 << i), pat(i + 40));
        end
        for (int a = 0; a < 32; a++) do_write(32, 5'(31 - a), 5'(a), pat(a));
        for (int a = 0; a < 32; a++) rd_chk("R7 test storage", 32, 5'(a), 5'(a), pat(a));

        // R11: clear command
        @(negedge mdc); clr_test = 1'b1;
        @(negedge mdc); clr_test = 1'b0;
        for (int a = 0; a < 32; a++) rd_chk("R11 cleared", 32, 5'd1, 5'(a), 16'h0000);

        test_mode = 1'b0;
        rd_chk("R3 normal again", 32, 5'd1, 5'd3, 16'h0C2A);
        rd_chk("R7 control kept out of test storage", 32, 5'd1, 5'd0, 16'h0140);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge mdc);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule